// File: doc/BRIEF.md
# Byte-Accessed 32-bit Symbol Counter

This block is a 32-bit free-running counter that a low-rate radio MAC uses as its symbol time base. It counts one step per symbol tick. The tick has two possible sources. The first is an enable produced by dividing the system clock by 256, which gives 62.5 kHz from 16 MHz. The second is a 32.768 kHz real-time clock tick, which is resynchronized inside the block and edge-detected.

A CPU reaches the counter through an 8-bit register bus. Reads are atomic across the byte lanes: a read of the low byte latches the whole 32-bit count into a shadow, and the three upper bytes are then served from that shadow. Writes to the upper bytes only fill staging registers. A write to the low byte commits the full word. With the system source the new value is loaded at once. With the RTC source it waits for the next counter tick, and the busy flag is held until then.

When the count wraps from all ones to zero, a sticky overflow flag is set. Software clears it by writing 1. An enable bit gates the flag onto the interrupt output.

Top module: `symbol_counter`

## Requirements
- R1: After reset the count is 0, rdata_o, busy_o and irq_o are 0, and the control register (address 4) reads 0, which selects the system-divided source with the interrupt disabled.
- R2: With the RTC source selected (control bit 0 = 1), each rising edge of rtc_tick_i raises the count by exactly one, within three clock cycles of the edge.
- R3: With the system source selected (control bit 0 = 0), the count rises by exactly one every 256 clock cycles.
- R4: A read of address 0 returns count bits 7:0 and copies all 32 bits into a shadow. Reads of addresses 1, 2 and 3 return shadow bits 15:8, 23:16 and 31:24, even if the count has changed since the snapshot. Read data appears on rdata_o in the cycle after the read strobe.
- R5: Writes to addresses 1 to 3 fill staging bytes 1 to 3. In RTC mode, a write to address 0 sets busy_o and leaves the count unchanged. At the next tick the count becomes {staging, written byte} in place of that tick's increment, and busy_o returns to 0.
- R6: While busy_o is 1, a write to address 0 is ignored, and writes to the staging bytes do not alter the pending value.
- R7: In system-source mode, a write to address 0 loads the count on that clock edge, and busy_o stays 0.
- R8: A tick that takes the count from 0xFFFFFFFF to 0x00000000 sets an overflow flag. The flag reads as bit 1 of the status register (address 5), whose bit 0 is busy. Writing 1 to status bit 1 clears the flag.
- R9: irq_o is the overflow flag ANDed with the interrupt enable, which is control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rtc_tick_i | input | 1 | Asynchronous RTC tick, counted on its rising edge |
| cs_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Byte address: 0-3 count bytes, 4 control, 5 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | Pending counter load in progress |
| irq_o | output | 1 | Overflow interrupt |

## Verification
On every cycle the assertions check how ticks relate to the count. Outside a load, a tick adds exactly one and no tick holds the count. They also check that a pending load ends busy on its tick, that busy survives extra commit attempts, that a system-mode commit never raises busy, that an enabled wrap sets the flag, and that the interrupt is gated. The bench scenarios show what the assertions cannot: the exact loaded values, the shadow staying frozen while the counter carries across bytes, the 256-cycle rate, and that an ignored write leaves the pending word intact.

// File: rtl/symcnt_pkg.sv
package symcnt_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NBYTES  = CNT_W / BYTE_W;
  localparam int unsigned BSEL_W  = $clog2(NBYTES);
  localparam int unsigned ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

  typedef struct packed {
    logic irq_en;
    logic src_rtc;
  } ctrl_t;
endpackage

// File: rtl/symcnt_tick_gen.sv
module symcnt_tick_gen #(
  parameter int unsigned DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_rtc_i,
  input  logic rtc_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic          sys_tick;
  logic [1:0]    sync_q;
  logic          prev_q;
  logic          rtc_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign sys_tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rtc_i};
      prev_q <= sync_q[1];
    end
  end

  assign rtc_rise = sync_q[1] & ~prev_q;
  assign tick_o   = src_rtc_i ? rtc_rise : sys_tick;
endmodule

// File: rtl/symcnt_core.sv
module symcnt_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             src_rtc_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_val_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, pend_q;
  logic             busy_q, flag_q;
  logic             accept, load_now, wrap;

  assign accept   = commit_i & ~busy_q;
  assign load_now = accept & ~src_rtc_i;
  assign wrap     = tick_i & ~busy_q & ~load_now & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (load_now) begin
        cnt_q <= commit_val_i;
      end else if (tick_i) begin
        if (busy_q) begin
          cnt_q  <= pend_q;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // deferred load waits for next tick
      if (accept && src_rtc_i) begin
        pend_q <= commit_val_i;
        busy_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (wrap) flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/symcnt_regs.sv
module symcnt_regs
  import symcnt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                busy_i,
  input  logic                flag_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output ctrl_t               ctrl_o,
  output logic                commit_o,
  output logic [CNT_W-1:0]    commit_val_o,
  output logic                flag_clr_o
);
  logic wr, rd, is_byte;
  logic [NBYTES-1:0][BYTE_W-1:0] shadow_q;
  logic [NBYTES-1:1][BYTE_W-1:0] stage_q;
  logic [BYTE_W-1:0] rd_mux;
  ctrl_t ctrl_q;

  assign wr      = cs_i & we_i;
  assign rd      = cs_i & ~we_i;
  assign is_byte = (int'(addr_i) < NBYTES);

  assign commit_o   = wr && (addr_i == '0);
  assign flag_clr_o = wr && (addr_i == ADDR_STAT) && wdata_i[1];
  assign commit_val_o[BYTE_W-1:0] = wdata_i;

  for (genvar b = 1; b < NBYTES; b++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[b] <= '0;
      else if (wr && (int'(addr_i) == b)) stage_q[b] <= wdata_i;
    end
    assign commit_val_o[b*BYTE_W +: BYTE_W] = stage_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr && (addr_i == ADDR_CTRL)) ctrl_q <= ctrl_t'(wdata_i[1:0]);
  end

  always_comb begin
    rd_mux = '0;
    if (is_byte) rd_mux = shadow_q[addr_i[BSEL_W-1:0]];
    else if (addr_i == ADDR_CTRL) rd_mux = BYTE_W'(ctrl_q);
    else if (addr_i == ADDR_STAT) rd_mux = BYTE_W'({flag_i, busy_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      rdata_o  <= '0;
    end else if (rd) begin
      if (addr_i == '0) begin
        shadow_q <= cnt_i;
        rdata_o  <= cnt_i[BYTE_W-1:0];
      end else begin
        rdata_o <= rd_mux;
      end
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/symbol_counter.sv
module symbol_counter
  import symcnt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_tick_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             src_rtc, irq_en;
  logic             tick, commit, flag_clr, flag;
  logic [CNT_W-1:0] cnt, commit_val;

  assign src_rtc = ctrl.src_rtc;
  assign irq_en  = ctrl.irq_en;

  symcnt_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_rtc_i (src_rtc),
    .rtc_i     (rtc_tick_i),
    .tick_o    (tick)
  );

  symcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .src_rtc_i    (src_rtc),
    .commit_i     (commit),
    .commit_val_i (commit_val),
    .flag_clr_i   (flag_clr),
    .cnt_o        (cnt),
    .busy_o       (busy_o),
    .flag_o       (flag)
  );

  symcnt_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_i         (cs_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .cnt_i        (cnt),
    .busy_i       (busy_o),
    .flag_i       (flag),
    .rdata_o      (rdata_o),
    .ctrl_o       (ctrl),
    .commit_o     (commit),
    .commit_val_o (commit_val),
    .flag_clr_o   (flag_clr)
  );

  assign irq_o = flag & irq_en;
endmodule

// File: rtl/symcnt_checker.sv
module symcnt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             busy_i,
  input logic             commit_i,
  input logic             src_rtc_i,
  input logic             flag_i,
  input logic             irq_en_i,
  input logic             irq_i
);
  logic sys_load;
  assign sys_load = commit_i & ~busy_i & ~src_rtc_i;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_i && !sys_load) |=> (cnt_i == $past(cnt_i) + 1'b1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !sys_load) |=> $stable(cnt_i));

  p_busy_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && tick_i) |=> !busy_i);

  p_busy_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick_i) |=> busy_i);

  p_sys_nobusy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_load |=> !busy_i);

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_i && !sys_load && (&cnt_i)) |=> (flag_i && cnt_i == '0));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i || !flag_i) |-> !irq_i);
endmodule

bind symbol_counter symcnt_checker #(.CNT_W(symcnt_pkg::CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .cnt_i     (cnt),
  .busy_i    (busy_o),
  .commit_i  (commit),
  .src_rtc_i (src_rtc),
  .flag_i    (flag),
  .irq_en_i  (irq_en),
  .irq_i     (irq_o)
);

// File: tb/tb_symbol_counter.sv
module tb_symbol_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rtc_tick_i = 1'b0;
  logic       cs_i = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  symbol_counter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rtc_tick_i(rtc_tick_i),
    .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .busy_o(busy_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    cs_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic read32(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      bus_rd(3'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic stage_commit(input logic [31:0] v);
    for (int i = 3; i >= 0; i--) bus_wr(3'(i), v[i*8 +: 8]);
  endtask

  task automatic rtc_pulse();
    @(negedge clk_i); rtc_tick_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rtc_tick_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic rtc_load(input logic [31:0] v);
    stage_commit(v);
    rtc_pulse();
  endtask

  task automatic t_reset();
    logic [7:0] b;
    logic [31:0] v;
    check("R1 rdata", 32'(rdata_o), 0);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    bus_rd(3'd4, b);
    check("R1 ctrl", 32'(b), 0);
    read32(v);
    check("R1 count", v, 0);
  endtask

  task automatic t_sys_rate();
    logic [7:0] a, b;
    bus_rd(3'd0, a);
    repeat (510) @(negedge clk_i);
    bus_rd(3'd0, b);
    check("R3 two ticks in 512 cycles", 32'(8'(b - a)), 2);
  endtask

  task automatic t_sys_write();
    logic [31:0] v;
    stage_commit(32'hCAFE_0100);
    check("R7 busy stays low", 32'(busy_o), 0);
    read32(v);
    checks++;
    if (v !== 32'hCAFE_0100 && v !== 32'hCAFE_0101) begin
      errors++;
      $display("FAIL R7: actual %h expected %h", v, 32'hCAFE_0100);
    end
  endtask

  task automatic t_rtc_count();
    logic [31:0] v;
    rtc_load(32'h0000_0100);
    for (int i = 0; i < 5; i++) rtc_pulse();
    read32(v);
    check("R2 five rtc edges", v, 32'h0000_0105);
  endtask

  task automatic t_atomic();
    logic [7:0] b;
    logic [31:0] v;
    rtc_load(32'h0001_FFFF);
    bus_rd(3'd0, b);
    check("R4 low byte", 32'(b), 32'hFF);
    rtc_pulse();
    bus_rd(3'd1, b);
    check("R4 shadow byte1", 32'(b), 32'hFF);
    bus_rd(3'd2, b);
    check("R4 shadow byte2", 32'(b), 32'h01);
    bus_rd(3'd3, b);
    check("R4 shadow byte3", 32'(b), 32'h00);
    read32(v);
    check("R4 fresh snapshot", v, 32'h0002_0000);
  endtask

  task automatic t_staged();
    logic [31:0] v;
    rtc_load(32'h0000_0040);
    stage_commit(32'h1234_5678);
    check("R5 busy set", 32'(busy_o), 1);
    read32(v);
    check("R5 count held before tick", v, 32'h0000_0040);
    rtc_pulse();
    check("R5 busy cleared", 32'(busy_o), 0);
    read32(v);
    check("R5 loaded value", v, 32'h1234_5678);
    rtc_pulse();
    read32(v);
    check("R5 counts after load", v, 32'h1234_5679);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    stage_commit(32'hA5A5_A5A5);
    bus_wr(3'd3, 8'h11);
    bus_wr(3'd0, 8'h22);
    check("R6 busy still set", 32'(busy_o), 1);
    rtc_pulse();
    read32(v);
    check("R6 pending kept", v, 32'hA5A5_A5A5);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    bus_wr(3'd4, 8'h03);
    rtc_load(32'hFFFF_FFFE);
    rtc_pulse();
    check("R8 no irq before wrap", 32'(irq_o), 0);
    rtc_pulse();
    check("R8 irq on wrap", 32'(irq_o), 1);
    read32(v);
    check("R8 wrapped count", v, 0);
    bus_wr(3'd5, 8'h02);
    check("R8 w1c clears", 32'(irq_o), 0);
  endtask

  task automatic t_irq_gate();
    logic [7:0] b;
    bus_wr(3'd4, 8'h01);
    rtc_load(32'hFFFF_FFFF);
    rtc_pulse();
    check("R9 gated irq", 32'(irq_o), 0);
    bus_rd(3'd5, b);
    check("R8 status flag", 32'(b), 32'h02);
    bus_wr(3'd4, 8'h03);
    check("R9 enabled irq", 32'(irq_o), 1);
    bus_wr(3'd5, 8'h02);
    bus_rd(3'd5, b);
    check("R8 status cleared", 32'(b), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sys_rate();
    t_sys_write();
    bus_wr(3'd4, 8'h01);
    t_rtc_count();
    t_atomic();
    t_staged();
    t_busy_ignore();
    t_overflow();
    t_irq_gate();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule